// File: doc/BRIEF.md
# Two-Level Masked Interrupt Combiner

This block merges interrupt requests from two subordinate source groups into one main source register and drives a single interrupt line toward a host processor. Each of the three groups (main, USB-core, DMA) holds a 32-bit pending register and a 32-bit mask register. Software raises pending bits through a set address, lowers them through a clear address, and reads the pending state back. Hardware event inputs raise pending bits directly. The USB-core group folds into two summary bits of the main register, one per half-word. The DMA group folds into a third summary bit.

The interrupt line takes its polarity from a configuration register. After the power-on input rises, the line is held inactive for a settle interval. Once that interval ends, the line follows the masked pending state. The settle interval is a parameter counted in clock cycles. Its default corresponds to half a second at a 50 MHz clock.

Top module: `irq_fold_ctrl`

## Requirements
- R1: The register window is decoded on 12-bit word addresses with bits 1:0 equal to zero. The main group uses 0x870 (pending), 0x874 (set), 0x878 (clear) and 0x87C (mask). The USB group uses 0x840, 0x844, 0x848 and 0x84C, and the DMA group uses 0x850, 0x854, 0x858 and 0x85C, in the same roles. The configuration register is at 0x83C.
- R2: A write to a group's set address ORs the write data into that group's pending register.
- R3: A write to a group's clear address removes every pending bit that is 1 in the write data.
- R4: A read of a group's pending, set or clear address returns that group's current pending value. A read of a mask address or of the configuration address returns the stored value. Every other address reads as zero.
- R5: Main bit 9 reads 1 exactly when some unmasked USB-group bit in 15:0 is pending. Main bit 8 reads 1 exactly when some unmasked USB-group bit in 31:16 is pending.
- R6: Main bit 24 reads 1 exactly when some unmasked DMA-group bit is pending.
- R7: Main bits 24, 9 and 8 are driven only by the summaries. Writing them through the main set or clear address leaves their read value unchanged.
- R8: After reset, the main mask reads 0xFFFFFFFF. All pending registers, the other masks and the configuration register read 0, and irq_out is 0.
- R9: When configuration bit 17 is 1, irq_out is high while any unmasked main bit is pending. When bit 17 is 0, irq_out is high while no unmasked main bit is pending.
- R10: After reset, and from the clock edge at which pwr_on is first seen high, irq_out stays 0. It starts to follow R9 exactly SETTLE_CYCLES edges later, provided pwr_on stays high for that whole time.
- R11: On every clock edge, a bit set in main_evt, usb_evt or dma_evt becomes pending in its group. This holds even if the same bit is cleared by a write in that cycle.
- R12: A write to a mask register changes the summaries and irq_out from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwr_on | input | 1 | Power-good level; a rising value starts the settle interval |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 12 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| main_evt | input | 32 | Hardware events into the main pending register |
| usb_evt | input | 32 | Hardware events into the USB-group pending register |
| dma_evt | input | 32 | Hardware events into the DMA-group pending register |
| irq_out | output | 1 | Interrupt line |

## Verification
The assertions assume that pwr_on and the event inputs are synchronous to clk. They also assume that only one register write occurs per cycle, and the single write port makes that unavoidable. The clear-drops property is armed only in cycles with no hardware event, because events are allowed to override a clear. The stimulus changes inputs only on falling edges. It runs the random register traffic with all event inputs quiet, so every random write is judged against the bench model alone. Event-versus-clear collisions are exercised only in one directed case.

// File: rtl/irq_fold_pkg.sv
package irq_fold_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NGRP   = 3;

  localparam int GI_MAIN = 0;
  localparam int GI_USB  = 1;
  localparam int GI_DMA  = 2;

  localparam logic [ADDR_W-1:0] OFS_CFG       = 12'h83C;
  localparam logic [ADDR_W-1:0] OFS_USB_BASE  = 12'h840;
  localparam logic [ADDR_W-1:0] OFS_DMA_BASE  = 12'h850;
  localparam logic [ADDR_W-1:0] OFS_MAIN_BASE = 12'h870;

  typedef enum logic [1:0] {
    SLOT_SRC = 2'd0,
    SLOT_SET = 2'd1,
    SLOT_CLR = 2'd2,
    SLOT_MSK = 2'd3
  } slot_e;

  localparam int BIT_RX  = 8;
  localparam int BIT_TX  = 9;
  localparam int BIT_DMA = 24;
  localparam int BIT_POL = 17;

  localparam logic [DATA_W-1:0] SUM_BITS =
    (DATA_W'(1) << BIT_RX) | (DATA_W'(1) << BIT_TX) | (DATA_W'(1) << BIT_DMA);
endpackage

// File: rtl/irq_src_group.sv
module irq_src_group #(
  parameter int W = 32,
  parameter logic [W-1:0] MASK_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         msk_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_evt,
  output logic [W-1:0] src_q,
  output logic [W-1:0] msk_q,
  output logic [W-1:0] pend
);
  logic [W-1:0] src_d;
  logic         src_en;

  always_comb begin
    src_d  = (src_q & ~(clr_we ? wdata : '0)) | (set_we ? wdata : '0) | hw_evt;
    src_en = set_we | clr_we | (|hw_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      msk_q <= MASK_RST;
    end else begin
      if (src_en) src_q <= src_d;
      if (msk_we) msk_q <= wdata;
    end
  end

  assign pend = src_q & ~msk_q;

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((src_q & $past(wdata)) == $past(wdata))) else $error("set lost"); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && hw_evt == '0) |=> ((src_q & $past(wdata)) == '0)) else $error("clear lost"); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we && hw_evt == '0) |=> $stable(src_q)) else $error("spurious change"); // R11
endmodule

// File: rtl/irq_settle_gate.sv
module irq_settle_gate #(
  parameter int SETTLE_CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  output logic gate_ok
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  logic          pwr_q, busy_q, gate_q;
  logic [CW-1:0] cnt_q;
  logic          busy_d, gate_d;
  logic [CW-1:0] cnt_d;
  logic          pwr_rise;

  assign pwr_rise = pwr_on & ~pwr_q;

  always_comb begin
    busy_d = busy_q;
    gate_d = gate_q;
    cnt_d  = cnt_q;
    if (pwr_rise) begin
      gate_d = 1'b0;
      busy_d = 1'b1;
      cnt_d  = CW'(SETTLE_CYCLES);
    end else if (busy_q) begin
      if (!pwr_on) begin
        busy_d = 1'b0;
      end else if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        gate_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      busy_q <= 1'b0;
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pwr_q  <= pwr_on;
      busy_q <= busy_d;
      gate_q <= gate_d;
      cnt_q  <= cnt_d;
    end
  end

  assign gate_ok = gate_q;

  AST_RISE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on) |=> !gate_ok) else $error("gate open after power rise"); // R10
  AST_OPEN_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_ok) |-> $past(pwr_on)) else $error("gate opened without power"); // R10
endmodule

// File: rtl/irq_fold_ctrl.sv
module irq_fold_ctrl
  import irq_fold_pkg::*;
#(
  parameter int SETTLE_CYCLES = 25_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] main_evt,
  input  logic [DATA_W-1:0] usb_evt,
  input  logic [DATA_W-1:0] dma_evt,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] GRP_BASE [NGRP] = '{OFS_MAIN_BASE, OFS_USB_BASE, OFS_DMA_BASE};
  localparam int HALF = DATA_W / 2;

  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [DATA_W-1:0] evt_v  [NGRP];
  logic [DATA_W-1:0] src_q  [NGRP];
  logic [DATA_W-1:0] msk_q  [NGRP];
  logic [DATA_W-1:0] pend_v [NGRP];
  logic [NGRP-1:0]   grp_hit;
  slot_e             slot;

  assign evt_v[GI_MAIN] = main_evt;
  assign evt_v[GI_USB]  = usb_evt;
  assign evt_v[GI_DMA]  = dma_evt;
  assign slot = slot_e'(reg_addr[3:2]);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] BASE = GRP_BASE[g];
    assign grp_hit[g] = (reg_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]) && (reg_addr[1:0] == 2'b00);
    irq_src_group #(
      .W(DATA_W),
      .MASK_RST((g == GI_MAIN) ? {DATA_W{1'b1}} : {DATA_W{1'b0}})
    ) u_grp (
      .clk    (clk),
      .rst_n  (rst_s2),
      .set_we (reg_wr && grp_hit[g] && slot == SLOT_SET),
      .clr_we (reg_wr && grp_hit[g] && slot == SLOT_CLR),
      .msk_we (reg_wr && grp_hit[g] && slot == SLOT_MSK),
      .wdata  (reg_wdata),
      .hw_evt (evt_v[g]),
      .src_q  (src_q[g]),
      .msk_q  (msk_q[g]),
      .pend   (pend_v[g])
    );
  end

  // configuration register
  logic [DATA_W-1:0] cfg_q, cfg_d;
  logic              cfg_en;
  assign cfg_en = reg_wr && (reg_addr == OFS_CFG);
  assign cfg_d  = reg_wdata;
  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2)     cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // summaries fold into the main register view
  logic              sum_tx, sum_rx, sum_dma;
  logic [DATA_W-1:0] main_eff, main_pend;
  logic              any_pend, gate_ok;

  always_comb begin
    sum_tx   = |pend_v[GI_USB][HALF-1:0];
    sum_rx   = |pend_v[GI_USB][DATA_W-1:HALF];
    sum_dma  = |pend_v[GI_DMA];
    main_eff = src_q[GI_MAIN] & ~SUM_BITS;
    main_eff[BIT_TX]  = sum_tx;
    main_eff[BIT_RX]  = sum_rx;
    main_eff[BIT_DMA] = sum_dma;
    main_pend = main_eff & ~msk_q[GI_MAIN];
    any_pend  = |main_pend;
  end

  irq_settle_gate #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_gate (
    .clk     (clk),
    .rst_n   (rst_s2),
    .pwr_on  (pwr_on),
    .gate_ok (gate_ok)
  );

  assign irq_out = gate_ok & (cfg_q[BIT_POL] ? any_pend : ~any_pend);

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CFG) reg_rdata = cfg_q;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_hit[g]) begin
        if (slot == SLOT_MSK)  reg_rdata = msk_q[g];
        else if (g == GI_MAIN) reg_rdata = main_eff;
        else                   reg_rdata = src_q[g];
      end
    end
  end

  AST_MUTED_LINE: assert property (@(posedge clk) disable iff (!rst_s2)
    !gate_ok |-> !irq_out) else $error("line active while muted"); // R10
endmodule

// File: tb/tb_irq_fold_ctrl.sv
module tb_irq_fold_ctrl;
  localparam int SETTLE = 16;

  logic        clk = 1'b0;
  logic        rst_n, pwr_on, reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, main_evt, usb_evt, dma_evt;
  logic        irq_out;

  irq_fold_ctrl #(.SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .main_evt(main_evt), .usb_evt(usb_evt), .dma_evt(dma_evt), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] m_src, m_msk, u_src, u_msk, d_src, d_msk, cfg;
  bit          gate;

  localparam logic [31:0] SUMS = 32'h0100_0300;

  function automatic logic [31:0] f_eff();
    logic [31:0] e;
    e = m_src & ~SUMS;
    e[9]  = |(u_src[15:0] & ~u_msk[15:0]);
    e[8]  = |(u_src[31:16] & ~u_msk[31:16]);
    e[24] = |(d_src & ~d_msk);
    return e;
  endfunction

  function automatic logic f_irq();
    logic any;
    any = |(f_eff() & ~m_msk);
    return gate && (cfg[17] ? any : !any);
  endfunction

  function automatic logic [31:0] f_read(logic [11:0] a);
    case (a)
      12'h83C: return cfg;
      12'h840, 12'h844, 12'h848: return u_src;
      12'h84C: return u_msk;
      12'h850, 12'h854, 12'h858: return d_src;
      12'h85C: return d_msk;
      12'h870, 12'h874, 12'h878: return f_eff();
      12'h87C: return m_msk;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_wr(logic [11:0] a, logic [31:0] d);
    case (a)
      12'h83C: cfg = d;
      12'h844: u_src |= d;
      12'h848: u_src &= ~d;
      12'h84C: u_msk = d;
      12'h854: d_src |= d;
      12'h858: d_src &= ~d;
      12'h85C: d_msk = d;
      12'h874: m_src |= d;
      12'h878: m_src &= ~d;
      12'h87C: m_msk = d;
      default: ;
    endcase
  endtask

  // drive at negedge, commit at posedge, return at next negedge
  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd_chk(string tag, logic [11:0] a);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, f_read(a));
  endtask

  localparam logic [11:0] WADDR [10] = '{12'h83C, 12'h844, 12'h848, 12'h84C, 12'h854,
                                          12'h858, 12'h85C, 12'h874, 12'h878, 12'h87C};
  localparam logic [11:0] RADDR [14] = '{12'h83C, 12'h840, 12'h844, 12'h848, 12'h84C, 12'h850,
                                          12'h858, 12'h85C, 12'h870, 12'h874, 12'h87C, 12'h860,
                                          12'h871, 12'h800};

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; pwr_on = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    main_evt = '0; usb_evt = '0; dma_evt = '0;
    m_src = 0; m_msk = '1; u_src = 0; u_msk = 0; d_src = 0; d_msk = 0; cfg = 0; gate = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset state
    chk("R8 irq_out", {31'b0, irq_out}, 32'h0);
    rd_chk("R8 main mask", 12'h87C);
    rd_chk("R8 main src", 12'h870);
    rd_chk("R8 usb mask", 12'h84C);
    rd_chk("R8 cfg", 12'h83C);

    // R10 settle: polarity low, nothing pending -> line would be high once open
    pwr_on = 1'b1;
    @(negedge clk);
    repeat (SETTLE - 1) @(negedge clk);
    chk("R10 still muted", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    gate = 1;
    chk("R10 opened", {31'b0, irq_out}, {31'b0, f_irq()});

    // R9 polarity high, nothing pending
    wr(12'h83C, 32'h0002_0000);
    chk("R9 high pol idle", {31'b0, irq_out}, {31'b0, f_irq()});
    // R5 TX summary with main unmasked on bit 9 only
    wr(12'h87C, ~32'h0000_0200);
    wr(12'h844, 32'h0000_0004);
    rd_chk("R5 tx summary", 12'h870);
    chk("R9 tx raises line", {31'b0, irq_out}, 32'h1);
    // R12 mask takes effect next cycle
    wr(12'h84C, 32'h0000_0004);
    rd_chk("R12 mask hides tx", 12'h870);
    chk("R12 line drops", {31'b0, irq_out}, 32'h0);
    // R5 RX half
    wr(12'h844, 32'h0001_0000);
    rd_chk("R5 rx summary", 12'h870);
    // R6 DMA summary
    wr(12'h854, 32'h8000_0000);
    rd_chk("R6 dma summary", 12'h870);
    // R7 software cannot touch summary bits
    wr(12'h874, 32'h0100_0300);
    rd_chk("R7 set summary bits", 12'h870);
    wr(12'h878, 32'h0100_0300);
    rd_chk("R7 clear summary bits", 12'h870);
    // R3 clear
    wr(12'h858, 32'hFFFF_FFFF);
    rd_chk("R3 dma cleared", 12'h850);
    // R4 aliases and holes
    rd_chk("R4 usb via clear addr", 12'h848);
    rd_chk("R4 hole", 12'h860);
    rd_chk("R4 misaligned", 12'h872);

    // R11 event beats a clear in the same cycle
    wr(12'h844, 32'h0000_00F0);
    usb_evt = 32'h0000_0010;
    reg_wr = 1'b1; reg_addr = 12'h848; reg_wdata = 32'h0000_00F0;
    @(negedge clk);
    reg_wr = 1'b0; usb_evt = '0;
    u_src = (u_src & ~32'h0000_00F0) | 32'h0000_0010;
    rd_chk("R11 event over clear", 12'h840);
    dma_evt = 32'h0000_0001; main_evt = 32'h0000_0001;
    @(negedge clk);
    dma_evt = '0; main_evt = '0;
    d_src |= 32'h1; m_src |= 32'h1;
    rd_chk("R11 dma event", 12'h850);
    rd_chk("R11 main event", 12'h870);

    // random traffic (R1 R2 R3 R4 R9 R12)
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = WADDR[$urandom_range(9)];
      d = $urandom;
      if ($urandom_range(1)) d &= $urandom & $urandom;
      wr(a, d);
      rd_chk("R1 R2 R3 random read", RADDR[$urandom_range(13)]);
      chk("R9 R12 random irq", {31'b0, irq_out}, {31'b0, f_irq()});
    end

    // R10 power drop and re-rise mutes again
    wr(12'h83C, 32'h0);
    wr(12'h87C, 32'hFFFF_FFFF);
    pwr_on = 1'b0;
    @(negedge clk);
    pwr_on = 1'b1;
    @(negedge clk);
    gate = 0;
    chk("R10 re-rise mutes", {31'b0, irq_out}, 32'h0);
    repeat (SETTLE) @(negedge clk);
    gate = 1;
    chk("R10 reopened", {31'b0, irq_out}, {31'b0, f_irq()});

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule